// File: doc/BRIEF.md
# Dual-Geometry Serial FIFO Pair

This block holds the transmit and receive data of a serial port in two 16-byte buffers. A single mode bit sets the shape of both. With the bit low, each buffer is 16 entries of one byte. With the bit high, each buffer is 4 entries of one 32-bit word. The bus side moves whole entries. The shifter side always moves single bytes, and in word mode a word is split into bytes, or built from them, least significant byte first.

Each direction compares its state against a programmable threshold to form a request level. That level serves both as the interrupt flag and as the DMA trigger. Transmit compares its free space, and receive compares its occupancy. Both are counted in entries of the current shape.

When the FIFO-enable bit is low, each direction acts as a single data register. The block also reports these conditions:
- transfer complete, when the transmit buffer is empty and the shifter is idle;
- a sticky overrun, when a received byte finds the receive buffer full.

Each direction has its own one-cycle clear.

Top module: `dual_geom_fifo`

## Requirements
- R1: After reset both buffers are empty (levels 0, txByteValid and rxValid low) and rxOverrun is low.
- R2: Byte mode (fifoEn=1, wordMode=0): the transmit buffer holds 16 entries, and bits 7:0 of each push reach txByte in push order. A push while holding 16 entries is ignored.
- R3: Word mode (fifoEn=1, wordMode=1): the transmit buffer holds 4 words, and a push while holding 4 words is ignored. The shifter receives bits 7:0, 15:8, 23:16 and then 31:24 of each word. txLevel drops only when the fourth byte of a word is taken.
- R4: Byte mode: the receive buffer holds 16 bytes. They are read in arrival order on rxRData[7:0], with rxRData[31:8] zero.
- R5: Word mode: every four received bytes form one entry, with the first byte in bits 7:0. rxLevel and rxValid change only when the fourth byte arrives.
- R6: With fifoEn=0, each direction holds one entry, and both thresholds act as 1 whatever their value.
- R7: txReq is high exactly when (capacity − txLevel) ≥ txThr, counted in entries of the current mode.
- R8: rxReq is high exactly when rxLevel ≥ rxThr.
- R9: txComplete is high exactly when txLevel is 0 and txShiftIdle is high.
- R10: A byte that arrives while the receive buffer is full is discarded, and the stored contents are unchanged. It sets rxOverrun, which stays set until errClr is pulsed.
- R11: txClr or rxClr empties only its own buffer by the next cycle, and it wins over a push in the same cycle.
- R12: A pop on an empty buffer, from either side, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| fifoEn | input | 1 | 1: buffered operation; 0: single data register |
| wordMode | input | 1 | 0: 16×8 shape; 1: 4×32 shape |
| txClr | input | 1 | Empty the transmit buffer |
| rxClr | input | 1 | Empty the receive buffer |
| errClr | input | 1 | Clear rxOverrun |
| txPush | input | 1 | Bus writes one transmit entry |
| txWData | input | 32 | Transmit entry (bits 7:0 in byte mode) |
| txThr | input | 5 | Transmit free-space threshold |
| txByteReq | input | 1 | Shifter takes the current transmit byte |
| txShiftIdle | input | 1 | Shifter has finished its last character, stop bits included |
| txByte | output | 8 | Next byte for the shifter |
| txByteValid | output | 1 | Transmit buffer not empty |
| txLevel | output | 5 | Transmit entries held |
| txReq | output | 1 | Transmit interrupt and DMA request |
| txComplete | output | 1 | Transfer complete |
| rxByteValid | input | 1 | Shifter delivers one received byte |
| rxByte | input | 8 | Received byte |
| rxPop | input | 1 | Bus reads one receive entry |
| rxThr | input | 5 | Receive fill threshold |
| rxRData | output | 32 | Head receive entry |
| rxValid | output | 1 | Receive buffer not empty |
| rxLevel | output | 5 | Receive entries held |
| rxReq | output | 1 | Receive interrupt and DMA request |
| rxOverrun | output | 1 | Sticky overrun flag |

## Verification
The bench uses the default geometry of 16 bytes with 4 bytes per word. In that geometry both buffers fill in a handful of operations, so the full boundary, the ignored extra push and the overrun are all reached in both shapes. The small word count also exercises pointer wrap in word mode. Thresholds are swept across the free-space and fill boundaries, and register mode is covered with thresholds above 1.

// File: rtl/dgf_pkg.sv
package dgf_pkg;
  localparam int unsigned FIFO_BYTES = 16;
  localparam int unsigned WORD_BYTES = 4;
  localparam int unsigned FIFO_WORDS = FIFO_BYTES / WORD_BYTES;
  localparam int unsigned ADDR_W = $clog2(FIFO_BYTES);
  localparam int unsigned LVL_W = $clog2(FIFO_BYTES + 1);
  localparam int unsigned SUB_W = $clog2(WORD_BYTES);
  localparam int unsigned BUS_W = 8 * WORD_BYTES;

  // strobes from a control unit to its storage array
  typedef struct packed {
    logic              wrEn;
    logic              wrWord;
    logic [ADDR_W-1:0] wrAddr;
    logic [ADDR_W-1:0] rdAddr;
  } storeCmd_t;
endpackage

// File: rtl/dgf_ctrl.sv
module dgf_ctrl
  import dgf_pkg::*;
#(
  parameter bit SHIFT_PUSH = 1'b0  // 1: shifter writes bytes (receive), 0: shifter reads bytes (transmit)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clr,
  input  logic             fifoEn,
  input  logic             wordMode,
  input  logic             busOp,
  input  logic             byteOp,
  input  logic             errClr,
  input  logic [LVL_W-1:0] thr,
  output storeCmd_t        cmd,
  output logic [LVL_W-1:0] level,
  output logic             empty,
  output logic             req,
  output logic             overrun
);
  logic [ADDR_W-1:0] wrPtr, rdPtr, wrBase, rdBase;
  logic [SUB_W-1:0]  sub;
  logic [LVL_W-1:0]  count, cap, thrEff;
  logic full, subLast, subStep, entryIn, entryOut, drop, errFlag;

  always_comb begin
    if (!fifoEn)       cap = LVL_W'(1);
    else if (wordMode) cap = LVL_W'(FIFO_WORDS);
    else               cap = LVL_W'(FIFO_BYTES);
    thrEff  = fifoEn ? thr : LVL_W'(1);
    full    = (count >= cap);
    empty   = (count == '0);
    subLast = !wordMode || (sub == SUB_W'(WORD_BYTES - 1));
    wrBase  = ADDR_W'({wrPtr, {SUB_W{1'b0}}});
    rdBase  = ADDR_W'({rdPtr, {SUB_W{1'b0}}});
  end

  generate
    if (SHIFT_PUSH) begin : g_rx
      always_comb begin
        subStep     = byteOp && !full;
        drop        = byteOp && full;
        entryIn     = subStep && subLast;
        entryOut    = busOp && !empty;
        cmd.wrEn    = subStep;
        cmd.wrWord  = 1'b0;
        cmd.wrAddr  = wordMode ? wrBase + ADDR_W'(sub) : wrPtr;
        cmd.rdAddr  = wordMode ? rdBase : rdPtr;
        req         = (count >= thrEff);
      end
    end else begin : g_tx
      always_comb begin
        subStep     = byteOp && !empty;
        drop        = 1'b0;
        entryIn     = busOp && !full;
        entryOut    = subStep && subLast;
        cmd.wrEn    = entryIn;
        cmd.wrWord  = wordMode;
        cmd.wrAddr  = wordMode ? wrBase : wrPtr;
        cmd.rdAddr  = wordMode ? rdBase + ADDR_W'(sub) : rdPtr;
        req         = ((cap - count) >= thrEff);
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0; rdPtr <= '0; sub <= '0; count <= '0;
    end else if (clr) begin
      wrPtr <= '0; rdPtr <= '0; sub <= '0; count <= '0;
    end else begin
      if (entryIn)  wrPtr <= (wrPtr == ADDR_W'(cap - 1'b1)) ? '0 : wrPtr + 1'b1;
      if (entryOut) rdPtr <= (rdPtr == ADDR_W'(cap - 1'b1)) ? '0 : rdPtr + 1'b1;
      if (subStep)  sub   <= subLast ? '0 : sub + 1'b1;
      count <= count + LVL_W'(entryIn) - LVL_W'(entryOut);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       errFlag <= 1'b0;
    else if (drop)   errFlag <= 1'b1;
    else if (errClr) errFlag <= 1'b0;
  end

  assign level   = count;
  assign overrun = errFlag;
endmodule

// File: rtl/dgf_store.sv
module dgf_store
  import dgf_pkg::*;
#(
  parameter int unsigned IN_W  = 8,
  parameter int unsigned OUT_W = 8
) (
  input  logic             clk,
  input  storeCmd_t        cmd,
  input  logic [IN_W-1:0]  wrData,
  output logic [OUT_W-1:0] rdData
);
  localparam int unsigned IN_BYTES  = IN_W / 8;
  localparam int unsigned OUT_BYTES = OUT_W / 8;

  logic [7:0] mem [FIFO_BYTES];

  always_ff @(posedge clk) begin
    for (int k = 0; k < IN_BYTES; k++) begin
      if (cmd.wrEn && (cmd.wrWord || (k == 0)))
        mem[cmd.wrAddr + ADDR_W'(k)] <= wrData[8*k +: 8];
    end
  end

  generate
    for (genvar k = 0; k < OUT_BYTES; k++) begin : g_rd
      assign rdData[8*k +: 8] = mem[cmd.rdAddr + ADDR_W'(k)];
    end
  endgenerate
endmodule

// File: rtl/dual_geom_fifo.sv
module dual_geom_fifo
  import dgf_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             fifoEn,
  input  logic             wordMode,
  input  logic             txClr,
  input  logic             rxClr,
  input  logic             errClr,
  input  logic             txPush,
  input  logic [BUS_W-1:0] txWData,
  input  logic [LVL_W-1:0] txThr,
  input  logic             txByteReq,
  input  logic             txShiftIdle,
  output logic [7:0]       txByte,
  output logic             txByteValid,
  output logic [LVL_W-1:0] txLevel,
  output logic             txReq,
  output logic             txComplete,
  input  logic             rxByteValid,
  input  logic [7:0]       rxByte,
  input  logic             rxPop,
  input  logic [LVL_W-1:0] rxThr,
  output logic [BUS_W-1:0] rxRData,
  output logic             rxValid,
  output logic [LVL_W-1:0] rxLevel,
  output logic             rxReq,
  output logic             rxOverrun
);
  storeCmd_t txCmd, rxCmd;
  logic txEmpty, rxEmpty, txOvr, rxOvr;
  logic [BUS_W-1:0] rxWord;

  dgf_ctrl #(.SHIFT_PUSH(1'b0)) u_txCtrl (
    .clk, .rstN, .clr(txClr), .fifoEn, .wordMode, .busOp(txPush), .byteOp(txByteReq),
    .errClr, .thr(txThr), .cmd(txCmd), .level(txLevel), .empty(txEmpty), .req(txReq),
    .overrun(txOvr));

  dgf_store #(.IN_W(BUS_W), .OUT_W(8)) u_txStore (
    .clk, .cmd(txCmd), .wrData(txWData), .rdData(txByte));

  dgf_ctrl #(.SHIFT_PUSH(1'b1)) u_rxCtrl (
    .clk, .rstN, .clr(rxClr), .fifoEn, .wordMode, .busOp(rxPop), .byteOp(rxByteValid),
    .errClr, .thr(rxThr), .cmd(rxCmd), .level(rxLevel), .empty(rxEmpty), .req(rxReq),
    .overrun(rxOvr));

  dgf_store #(.IN_W(8), .OUT_W(BUS_W)) u_rxStore (
    .clk, .cmd(rxCmd), .wrData(rxByte), .rdData(rxWord));

  assign txByteValid = !txEmpty;
  assign txComplete  = txEmpty && txShiftIdle;
  assign rxValid     = !rxEmpty;
  assign rxRData     = wordMode ? rxWord : {{(BUS_W-8){1'b0}}, rxWord[7:0]};
  // the transmit control never discards, so its flag stays low
  assign rxOverrun   = rxOvr | txOvr;
endmodule

// File: rtl/dgf_checker.sv
module dgf_checker
  import dgf_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             txClr,
  input logic             rxClr,
  input logic             errClr,
  input logic             rxByteValid,
  input logic             rxOverrun,
  input logic             rxReq,
  input logic             rxValid,
  input logic [LVL_W-1:0] txLevel,
  input logic [LVL_W-1:0] rxLevel,
  input logic [LVL_W-1:0] rxThr
);
  p_level_cap_r2: assert property (@(posedge clk) disable iff (!rstN)
    (txLevel <= LVL_W'(FIFO_BYTES)) && (rxLevel <= LVL_W'(FIFO_BYTES)));

  p_level_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    !txClr |=> ((int'(txLevel) - int'($past(txLevel)) <= 1) &&
                (int'($past(txLevel)) - int'(txLevel) <= 1)));

  p_tx_clear_r11: assert property (@(posedge clk) disable iff (!rstN)
    txClr |=> (txLevel == '0));

  p_rx_clear_r11: assert property (@(posedge clk) disable iff (!rstN)
    rxClr |=> (rxLevel == '0));

  p_overrun_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rxOverrun && !errClr) |=> rxOverrun);

  p_overrun_cause_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!rxOverrun && !rxByteValid) |=> !rxOverrun);

  p_rx_req_data_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rxReq && (rxThr != '0)) |-> rxValid);
endmodule

bind dual_geom_fifo dgf_checker u_chk (.*);

// File: tb/tb_dual_geom_fifo.sv
`timescale 1ns/1ps
module tb_dual_geom_fifo;
  logic clk = 1'b0, rstN = 1'b0;
  logic fifoEn = 1'b1, wordMode = 1'b0, txClr = 1'b0, rxClr = 1'b0, errClr = 1'b0;
  logic txPush = 1'b0, txByteReq = 1'b0, txShiftIdle = 1'b1;
  logic [31:0] txWData = '0;
  logic [4:0] txThr = 5'd1, rxThr = 5'd1;
  logic rxByteValid = 1'b0, rxPop = 1'b0;
  logic [7:0] rxByte = '0;
  logic [7:0] txByte;
  logic txByteValid, txReq, txComplete, rxValid, rxReq, rxOverrun;
  logic [4:0] txLevel, rxLevel;
  logic [31:0] rxRData;

  int checks = 0, failures = 0;
  logic [7:0]  txExp[$];
  logic [31:0] rxExp[$];
  logic [31:0] rxAsm = '0;
  int rxAsmCnt = 0;

  always #10 clk = ~clk;

  dual_geom_fifo dut (.*);

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: compares bytes and words as they leave the design
  initial forever begin
    @(negedge clk); #8;
    if (txByteReq && txByteValid) begin
      if (txExp.size() == 0) check("R2", "unexpected tx byte", int'(txByte), -1);
      else check("R3", "tx byte order", int'(txByte), int'(txExp.pop_front()));
    end
    if (rxPop && rxValid) begin
      if (rxExp.size() == 0) check("R4", "unexpected rx entry", int'(rxRData), -1);
      else check("R5", "rx entry order", int'(rxRData), int'(rxExp.pop_front()));
    end
  end

  task automatic pushTx(input logic [31:0] d, input bit accepted);
    @(negedge clk); txPush = 1'b1; txWData = d;
    if (accepted) begin
      if (wordMode) for (int b = 0; b < 4; b++) txExp.push_back(d[8*b +: 8]);
      else txExp.push_back(d[7:0]);
    end
    @(negedge clk); txPush = 1'b0;
  endtask

  task automatic popTx();
    @(negedge clk); txByteReq = 1'b1;
    @(negedge clk); txByteReq = 1'b0;
  endtask

  task automatic sendRx(input logic [7:0] b, input bit accepted);
    @(negedge clk); rxByteValid = 1'b1; rxByte = b;
    if (accepted) begin
      if (wordMode) begin
        rxAsm[8*rxAsmCnt +: 8] = b; rxAsmCnt++;
        if (rxAsmCnt == 4) begin rxExp.push_back(rxAsm); rxAsmCnt = 0; end
      end else rxExp.push_back({24'h0, b});
    end
    @(negedge clk); rxByteValid = 1'b0;
  endtask

  task automatic popRx();
    @(negedge clk); rxPop = 1'b1;
    @(negedge clk); rxPop = 1'b0;
  endtask

  task automatic clearBoth();
    @(negedge clk); txClr = 1'b1; rxClr = 1'b1;
    @(negedge clk); txClr = 1'b0; rxClr = 1'b0;
    txExp.delete(); rxExp.delete(); rxAsmCnt = 0;
  endtask

  task automatic pulseErrClr();
    @(negedge clk); errClr = 1'b1;
    @(negedge clk); errClr = 1'b0;
  endtask

  task automatic settle();
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); settle();
    check("R1", "tx level", txLevel, 0);
    check("R1", "rx level", rxLevel, 0);
    check("R1", "overrun", rxOverrun, 0);
    check("R1", "tx valid", txByteValid, 0);
    check("R1", "rx valid", rxValid, 0);
    check("R9", "complete at idle", txComplete, 1);

    // byte mode transmit
    for (int i = 0; i < 12; i++) pushTx({24'hABCDEF, 8'(i*17+3)}, 1'b1);
    settle();
    check("R2", "tx level 12", txLevel, 12);
    txThr = 5'd4; settle(); check("R7", "free 4 thr 4", txReq, 1);
    txThr = 5'd5; settle(); check("R7", "free 4 thr 5", txReq, 0);
    for (int i = 12; i < 16; i++) pushTx({24'h123456, 8'(i*17+3)}, 1'b1);
    txThr = 5'd1; settle();
    check("R7", "full thr 1", txReq, 0);
    pushTx(32'h000000EE, 1'b0); settle();
    check("R2", "push on full ignored", txLevel, 16);
    check("R9", "not complete with data", txComplete, 0);
    for (int i = 0; i < 16; i++) popTx();
    settle();
    check("R2", "tx drained", txLevel, 0);
    check("R2", "tx queue used", txExp.size(), 0);
    popTx(); settle();
    check("R12", "tx pop on empty", txLevel, 0);
    txShiftIdle = 1'b0; settle(); check("R9", "shifter busy", txComplete, 0);
    txShiftIdle = 1'b1; settle(); check("R9", "shifter idle", txComplete, 1);

    // byte mode receive and overrun
    for (int i = 0; i < 16; i++) sendRx(8'(i*29+5), 1'b1);
    settle();
    check("R4", "rx level 16", rxLevel, 16);
    rxThr = 5'd16; settle(); check("R8", "fill 16 thr 16", rxReq, 1);
    rxThr = 5'd17; settle(); check("R8", "fill 16 thr 17", rxReq, 0);
    sendRx(8'hC3, 1'b0); settle();
    check("R10", "overrun set", rxOverrun, 1);
    check("R10", "level after overrun", rxLevel, 16);
    @(negedge clk); settle();
    check("R10", "overrun sticky", rxOverrun, 1);
    for (int i = 0; i < 16; i++) popRx();
    settle();
    check("R4", "rx drained", rxLevel, 0);
    popRx(); settle();
    check("R12", "rx pop on empty", rxLevel, 0);
    pulseErrClr(); settle();
    check("R10", "overrun cleared", rxOverrun, 0);

    // word mode
    clearBoth(); wordMode = 1'b1; txThr = 5'd1; rxThr = 5'd1;
    for (int i = 0; i < 4; i++) pushTx(32'h11223344 + 32'(i) * 32'h01010101, 1'b1);
    pushTx(32'hDEADBEEF, 1'b0); settle();
    check("R3", "tx word level", txLevel, 4);
    check("R7", "word full thr 1", txReq, 0);
    for (int i = 0; i < 3; i++) popTx();
    settle(); check("R3", "level holds mid word", txLevel, 4);
    popTx(); settle();
    check("R3", "level after word", txLevel, 3);
    check("R7", "one word free", txReq, 1);
    txThr = 5'd2; settle(); check("R7", "one word free thr 2", txReq, 0);
    for (int i = 0; i < 12; i++) popTx();
    settle(); check("R3", "tx words drained", txLevel, 0);
    check("R3", "tx byte queue used", txExp.size(), 0);

    for (int i = 0; i < 3; i++) sendRx(8'(i + 8'hA0), 1'b1);
    settle();
    check("R5", "partial word level", rxLevel, 0);
    check("R5", "partial word valid", rxValid, 0);
    sendRx(8'hA3, 1'b1); settle();
    check("R5", "word complete level", rxLevel, 1);
    check("R8", "word fill thr 1", rxReq, 1);
    for (int i = 0; i < 12; i++) sendRx(8'(i*7 + 1), 1'b1);
    sendRx(8'h99, 1'b0); settle();
    check("R10", "word overrun", rxOverrun, 1);
    check("R10", "word level kept", rxLevel, 4);
    for (int i = 0; i < 4; i++) popRx();
    settle(); check("R5", "rx words drained", rxLevel, 0);
    pulseErrClr();

    // single register mode
    clearBoth(); wordMode = 1'b0; fifoEn = 1'b0; txThr = 5'd5; rxThr = 5'd5; settle();
    check("R6", "register empty req", txReq, 1);
    pushTx(32'h0000005A, 1'b1); settle();
    check("R6", "register tx level", txLevel, 1);
    check("R6", "register tx full req", txReq, 0);
    pushTx(32'h000000A5, 1'b0); settle();
    check("R6", "register second push ignored", txLevel, 1);
    popTx();
    sendRx(8'h3C, 1'b1); settle();
    check("R6", "register rx req", rxReq, 1);
    sendRx(8'hC3, 1'b0); settle();
    check("R6", "register rx overrun", rxOverrun, 1);
    popRx(); pulseErrClr();

    // clear priority and independence
    fifoEn = 1'b1; rxThr = 5'd1; txThr = 5'd1;
    sendRx(8'h11, 1'b1); sendRx(8'h22, 1'b1);
    @(negedge clk); txPush = 1'b1; txWData = 32'h77; txClr = 1'b1;
    @(negedge clk); txPush = 1'b0; txClr = 1'b0; settle();
    check("R11", "clear beats push", txLevel, 0);
    check("R11", "rx untouched", rxLevel, 2);
    popRx(); popRx(); settle();
    check("R11", "rx entries intact", rxExp.size(), 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule